// File: doc/BRIEF.md
# Configurable-Frame Asynchronous Serial Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single line that rests high. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period of one, one and a half or two bit times. Bit timing comes from an external rate-enable pulse (`tick`). Every bit lasts a fixed number of these pulses, 16 by default.

A word is offered with a valid/ready handshake. When the word is accepted, the block also captures the five frame-shape inputs, so software-side changes to them cannot corrupt a frame already in flight. `busy` stays high from the cycle after acceptance until the final stop tick has been consumed. The block then takes the next word.

Parity can be computed from the data as odd or as even. In the fixed ("sticky") parity mode it is instead a constant bit, and that bit is the inverse of the even-select input. A stop-select input lengthens the stop period to two bit times. For 5-bit words it lengthens it to one and a half bit times instead.

Top module: `uart_frame_tx`

## Requirements
- R1: During and after a synchronous active-high reset, with no word accepted, `tx_line` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` is 1 and `in_ready` is 0 until the frame ends. After the frame ends, both return to their idle values.
- R3: The frame starts with a low start bit lasting 16 ticks. Data bits follow, LSB first, 16 ticks each. The number of data bits is 5 + `cfg_wlen` (0→5, 1→6, 2→7, 3→8), and data bits above that count are not sent.
- R4: With `cfg_par_en` = 0 there is no parity slot: the stop period directly follows the last data bit, whatever the values of `cfg_par_stick` and `cfg_par_even`.
- R5: With parity on and `cfg_par_stick` = 0, a 16-tick parity bit follows the last data bit. With `cfg_par_even` = 0 it makes the count of ones over the sent data bits plus parity odd, and with `cfg_par_even` = 1 it makes that count even. Examples: 8-bit 0x60 odd → 1, 0x57 odd → 0, 0x60 even → 0.
- R6: With parity on and `cfg_par_stick` = 1, the parity bit equals the inverse of `cfg_par_even`, independent of the data.
- R7: With `cfg_two_stop` = 0 the stop period is high for 16 ticks.
- R8: With `cfg_two_stop` = 1 and `cfg_wlen` ≠ 0 the stop period is high for 32 ticks.
- R9: With `cfg_two_stop` = 1 and `cfg_wlen` = 0 the stop period is high for 24 ticks.
- R10: The configuration and data are captured at acceptance. Changes to `in_data` or to any `cfg_*` input while `busy` is 1 do not alter the frame being sent.
- R11: `tx_line` changes only in the cycle after a cycle with `tick` = 1 or with an accepted word. Ticks while idle leave the line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-rate enable pulse, 16 per bit |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | DATA_W (8) | Parallel data word |
| cfg_wlen | input | 2 | Word length: data bits = 5 + value |
| cfg_two_stop | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | Even parity select (inverse is the fixed bit in sticky mode) |
| cfg_par_stick | input | 1 | Fixed parity select |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The sweep covers every word length, both stop settings and five parity settings: off, odd, even, fixed-one and fixed-zero. Each setting is tried with four data words, including the parity example values. Checks on the waveform at every tick, grouped by start, data, parity and stop segment, separate a wrong bit order or word-length mask from a wrong parity polarity and from a wrong stop length. The 24-tick versus 32-tick stop check tells the 5-bit special case apart from the other lengths. In the parity-off frames the sticky and even inputs are set to varied junk values, and the inputs are scrambled right after acceptance, so that leaks of live inputs into the frame are exposed.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        STOP_ONE     = 2'd0,
        STOP_ONEHALF = 2'd1,
        STOP_TWO     = 2'd2
    } stop_kind_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    // Length of the stop period for a captured configuration.
    function automatic stop_kind_e stop_kind(input frame_cfg_t c);
        if (!c.two_stop)
            return STOP_ONE;
        else if (c.wlen == 2'd0)
            return STOP_ONEHALF;
        else
            return STOP_TWO;
    endfunction

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             period_end
);
    logic [CNT_W-1:0] cnt;

    assign period_end = active && tick && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt <= '0;
        else if (period_end)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NB_W   = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [NB_W-1:0]   nbits,
    input  frame_cfg_t        cfg,
    output logic              par_val
);
    logic [DATA_W-1:0] used;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_mask
            assign used[i] = data[i] & (NB_W'(i) < nbits);
        end
    endgenerate

    // Computed parity: even select picks XOR, otherwise its complement.
    assign par_val = cfg.par_stick ? ~cfg.par_even
                                   : ((^used) ^ ~cfg.par_even);
endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int NB_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              period_end,
    input  logic              par_en,
    input  logic              par_val,
    input  logic [NB_W-1:0]   nbits,
    input  logic [DATA_W-1:0] data,
    output phase_e            phase,
    output logic              tx_line,
    output logic              busy
);
    phase_e           phase_q;
    logic [IDX_W-1:0] idx;
    logic             last_data;

    assign last_data = (NB_W'(idx) == (nbits - NB_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx     <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_START;
                        idx     <= '0;
                    end
                end
                PH_START: if (period_end) phase_q <= PH_DATA;
                PH_DATA: begin
                    if (period_end) begin
                        if (last_data)
                            phase_q <= par_en ? PH_PAR : PH_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                PH_PAR:  if (period_end) phase_q <= PH_STOP;
                PH_STOP: if (period_end) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (phase_q)
            PH_START: tx_line = 1'b0;
            PH_DATA:  tx_line = data[idx];
            PH_PAR:   tx_line = par_val;
            default:  tx_line = 1'b1;
        endcase
    end

    assign busy  = (phase_q != PH_IDLE);
    assign phase = phase_q;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    output logic              tx_line,
    output logic              busy
);
    localparam int MIN_BITS = DATA_W - 3;
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int NB_W     = IDX_W + 1;
    localparam int CNT_W    = $clog2(2 * TICKS_PER_BIT);

    localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

    frame_cfg_t        cfg_in, cfg_q;
    logic [DATA_W-1:0] data_q;
    logic [NB_W-1:0]   nbits;
    logic [CNT_W-1:0]  stop_lim, limit;
    logic              accept, period_end, par_val;
    phase_e            phase;

    assign cfg_in = '{wlen: cfg_wlen, two_stop: cfg_two_stop, par_en: cfg_par_en,
                      par_even: cfg_par_even, par_stick: cfg_par_stick};

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            cfg_q  <= cfg_in;
            data_q <= in_data;
        end
    end

    assign nbits = NB_W'(MIN_BITS) + NB_W'(cfg_q.wlen);

    always_comb begin
        case (stop_kind(cfg_q))
            STOP_ONEHALF: stop_lim = LIM_HALF;
            STOP_TWO:     stop_lim = LIM_TWO;
            default:      stop_lim = LIM_ONE;
        endcase
    end

    assign limit = (phase == PH_STOP) ? stop_lim : LIM_ONE;

    uart_tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .active     (busy),
        .tick       (tick),
        .limit      (limit),
        .period_end (period_end)
    );

    uart_tx_parity #(.DATA_W(DATA_W), .NB_W(NB_W)) u_parity (
        .data    (data_q),
        .nbits   (nbits),
        .cfg     (cfg_q),
        .par_val (par_val)
    );

    uart_tx_sequencer #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NB_W(NB_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .period_end (period_end),
        .par_en     (cfg_q.par_en),
        .par_val    (par_val),
        .nbits      (nbits),
        .data       (data_q),
        .phase      (phase),
        .tx_line    (tx_line),
        .busy       (busy)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
    import uart_tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       in_valid,
    input logic       in_ready,
    input logic       busy,
    input logic       tx_line,
    input phase_e     phase,
    input frame_cfg_t cfg_q
);
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !in_ready));

    assert_no_parity_slot_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.par_en |-> (phase != PH_PAR));

    assert_fixed_parity_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAR && cfg_q.par_stick) |-> (tx_line == !cfg_q.par_even));

    assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));

    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    assert_line_steady_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && !$past(in_valid && in_ready)) |-> $stable(tx_line));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .tx_line  (tx_line),
    .phase    (phase),
    .cfg_q    (cfg_q)
);

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [1:0] cfg_wlen = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       tx_line;
    logic       busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_frame_tx u0 (
        .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
        .tx_line(tx_line), .busy(busy)
    );

    // Rate pulse: high every other cycle.
    initial forever begin
        @(posedge clk);
        tick <= ~tick;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int wl, input bit two,
                              input bit pen, input bit pev, input bit pst);
        int nb, ones, par_on, stop_t, len, k, b, e, seg;
        int err[5];
        int act[5];
        int expv[5];
        bit par;
        string lbl[5];
        nb     = 5 + wl;
        par_on = pen ? 1 : 0;
        ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        if (pst)      par = !pev;
        else if (pev) par = (ones % 2) == 1;
        else          par = (ones % 2) == 0;
        stop_t = !two ? 16 : ((wl == 0) ? 24 : 32);
        len    = 16 * (1 + nb + par_on) + stop_t;
        lbl[0] = "R3 start";
        lbl[1] = "R3/R10 data";
        lbl[2] = pst ? "R6 parity" : "R5 parity";
        lbl[3] = !two ? "R7/R4 stop" : ((wl == 0) ? "R9/R4 stop" : "R8/R4 stop");
        lbl[4] = "R11 between ticks";
        for (int i = 0; i < 5; i++) begin err[i] = 0; act[i] = 0; expv[i] = 0; end

        @(negedge clk);
        in_data = d; cfg_wlen = 2'(wl); cfg_two_stop = two; cfg_par_en = pen;
        cfg_par_even = pev; cfg_par_stick = pst; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // Scramble live inputs during the frame (R10).
        in_data = ~d; cfg_wlen = ~cfg_wlen; cfg_two_stop = ~two; cfg_par_en = ~pen;
        cfg_par_even = ~pev; cfg_par_stick = ~pst;
        check(busy && !in_ready, "R2 busy after accept", {30'd0, busy, in_ready}, 2);

        k = 0;
        while (k < len) begin
            b = k / 16;
            if (b == 0)                          begin e = 0;        seg = 0; end
            else if (b <= nb)                    begin e = d[b-1];   seg = 1; end
            else if (pen && b == nb + 1)         begin e = par;      seg = 2; end
            else                                 begin e = 1;        seg = 3; end
            if (!tick) seg = 4;
            if ((int'(tx_line) != e || !busy) && err[seg] == 0) begin
                act[seg]  = busy ? int'(tx_line) : 9;
                expv[seg] = e;
                err[seg]  = 1;
            end
            if (tick) k++;
            if (k < len) @(negedge clk);
        end
        for (int s = 0; s < 5; s++) begin
            if (s != 2 || pen) check(err[s] == 0, lbl[s], act[s], expv[s]);
        end
        @(negedge clk);
        check(!busy && in_ready && tx_line, "R2/R7 idle after frame",
              {29'd0, busy, in_ready, tx_line}, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] pats[4];
        pats[0] = 8'h60; pats[1] = 8'h57; pats[2] = 8'hA5; pats[3] = 8'h1F;
        repeat (4) @(negedge clk);
        check(tx_line && !busy && in_ready, "R1 in reset", {29'd0, tx_line, busy, in_ready}, 5);
        rst = 1'b0;
        // Idle ticks must not move the line (R1, R11).
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(tx_line && !busy && in_ready, "R1/R11 idle", {29'd0, tx_line, busy, in_ready}, 5);
        end
        for (int wl = 0; wl < 4; wl++)
            for (int two = 0; two < 2; two++)
                for (int pm = 0; pm < 5; pm++)
                    for (int di = 0; di < 4; di++) begin
                        case (pm)
                            0: send_frame(pats[di], wl, two[0], 1'b0, di[1], di[0]);
                            1: send_frame(pats[di], wl, two[0], 1'b1, 1'b0, 1'b0);
                            2: send_frame(pats[di], wl, two[0], 1'b1, 1'b1, 1'b0);
                            3: send_frame(pats[di], wl, two[0], 1'b1, 1'b0, 1'b1);
                            default: send_frame(pats[di], wl, two[0], 1'b1, 1'b1, 1'b1);
                        endcase
                    end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule